// File: doc/BRIEF.md
# Keyboard Controller Power-Down Sequencer

This block controls clock gating around a small embedded keyboard-controller microcontroller core. The core can ask for one of two power-saving depths. A shallow sleep, requested by a halt strobe, gates only the arithmetic unit's clock. The timer/counter and interrupt logic keep their clock, so they go on running. A deep sleep, requested by a stop strobe, removes the oscillator enable, and with it every clock of the core.

The core leaves either depth when its reset input is asserted or when the host writes a byte into the core's input data buffer. After a deep sleep, the oscillator is enabled again. The core clocks stay gated until the oscillator has been stable for a programmable number of reference cycles. On leaving a sleep, the block sends one wake strobe. With the strobe it gives a 2-bit resume code that tells the core where to continue: at the next instruction, with a call to the input-buffer interrupt routine, or at the reset vector (address 0).

The block runs on an always-on reference clock and has its own asynchronous reset. All pins are plain control and status levels or strobes. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `kbc_pwr_seq`

## Requirements
- R1: After `arst_n` is released, the block is awake: `osc_en`, `core_clk_en` and `alu_clk_en` are 1, `wake_stb` is 0 and `resume_code` is 00.
- R2: A `halt_req` while awake (and with no `stop_req`) gives, from the next cycle on, `alu_clk_en`=0 while `core_clk_en`=1 and `osc_en`=1 (shallow sleep).
- R3: A `stop_req` while awake or in shallow sleep gives, from the next cycle on, `osc_en`=`core_clk_en`=`alu_clk_en`=0 (deep sleep). `stop_req` wins over `halt_req` when both arrive in the same cycle.
- R4: In shallow sleep, a `host_wr` with no `core_reset` gives, in the next cycle, all enables 1 and a one-cycle `wake_stb`. With it, `resume_code` is 01 (interrupt call) when `ibf_ie` was 1 and 00 (next instruction) when `ibf_ie` was 0.
- R5: A wake by `core_reset` gives `resume_code` 10 (reset vector). When `core_reset` and `host_wr` arrive in the same cycle, `core_reset` wins, both in shallow and in deep sleep.
- R6: In deep sleep, a wake gives `osc_en`=1 in the next cycle. `core_clk_en` and `alu_clk_en` stay 0 until `osc_ready` has been 1 for `settle_len`+1 consecutive cycles. They rise, together with `wake_stb`, right after the last of those cycles. A cycle with `osc_ready`=0 restarts the count.
- R7: While the oscillator settles, `halt_req`, `stop_req` and `host_wr` are ignored: the release time and the resume code stay as they were. A `core_reset` in that window changes the pending code to 10.
- R8: `wake_stb` is never high for two cycles in a row, and `resume_code` is 00 whenever `wake_stb` is 0.
- R9: While awake, `host_wr` and `core_reset` produce no `wake_stb` and leave the enables at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on reference clock |
| arst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| halt_req | input | 1 | Strobe from the core: enter shallow sleep |
| stop_req | input | 1 | Strobe from the core: enter deep sleep |
| core_reset | input | 1 | Core reset level; wakes the core to the reset vector |
| host_wr | input | 1 | Strobe: the host wrote the input data buffer |
| ibf_ie | input | 1 | Input-buffer-full interrupt enable of the core |
| osc_ready | input | 1 | Oscillator output is running |
| settle_len | input | CNT_W | Extra stable cycles required before the clocks are released |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Clock enable for the timer/counter and interrupt logic |
| alu_clk_en | output | 1 | Clock enable for the arithmetic unit and instruction flow |
| wake_stb | output | 1 | One-cycle strobe when the core resumes |
| resume_code | output | 2 | 00 next instruction, 01 interrupt call, 10 reset vector; valid with `wake_stb` |

## Verification
The hardest case to reach from the ports is the settling window after a deep sleep. There, the stable-cycle count, a restart of that count, ignored sleep requests and a change of the pending resume code all meet. The bench reaches it by first sending a stop strobe and then a wake while it holds `osc_ready` under its own control. It sweeps `settle_len` and the wake source, and it drops `osc_ready` or sends halt, stop, host-write and reset pulses in the middle of the window. For each case it counts the cycles until release and compares them with `settle_len`+1.

// File: rtl/kbc_pwr_pkg.sv
package kbc_pwr_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_SHALLOW = 2'd1,
    ST_DEEP   = 2'd2,
    ST_SETTLE = 2'd3
  } pwr_state_t;

  typedef enum logic [1:0] {
    RES_NEXT = 2'b00,
    RES_IRQ  = 2'b01,
    RES_RST  = 2'b10
  } resume_t;
endpackage

// File: rtl/kbc_pwr_settle.sv
module kbc_pwr_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             active,
  input  logic             stable,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = active && stable && (cnt == limit);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                cnt <= '0;
    else if (!active || !stable) cnt <= '0;
    else if (!done)             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/kbc_pwr_fsm.sv
module kbc_pwr_fsm
  import kbc_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       halt_req,
  input  logic       stop_req,
  input  logic       core_reset,
  input  logic       host_wr,
  input  logic       ibf_ie,
  input  logic       settle_done,
  output pwr_state_t state,
  output logic       wake_stb,
  output logic [1:0] resume_code
);
  pwr_state_t nxt;
  resume_t    pend_q, pend_d, wake_code;
  logic       wake_req, fire;

  assign wake_req  = core_reset || host_wr;
  assign wake_code = core_reset ? RES_RST : (ibf_ie ? RES_IRQ : RES_NEXT);

  always_comb begin
    nxt    = state;
    pend_d = pend_q;
    fire   = 1'b0;
    unique case (state)
      ST_AWAKE: begin
        if (stop_req)      nxt = ST_DEEP;
        else if (halt_req) nxt = ST_SHALLOW;
      end
      ST_SHALLOW: begin
        if (wake_req) begin
          nxt    = ST_AWAKE;
          fire   = 1'b1;
          pend_d = wake_code;
        end else if (stop_req) begin
          nxt = ST_DEEP;
        end
      end
      ST_DEEP: begin
        if (wake_req) begin
          nxt    = ST_SETTLE;
          pend_d = wake_code;
        end
      end
      ST_SETTLE: begin
        if (core_reset) pend_d = RES_RST;
        if (settle_done) begin
          nxt  = ST_AWAKE;
          fire = 1'b1;
        end
      end
      default: nxt = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state       <= ST_AWAKE;
      pend_q      <= RES_NEXT;
      wake_stb    <= 1'b0;
      resume_code <= 2'b00;
    end else begin
      state       <= nxt;
      pend_q      <= pend_d;
      wake_stb    <= fire;
      resume_code <= fire ? pend_d : 2'b00;
    end
  end
endmodule

// File: rtl/kbc_pwr_seq.sv
module kbc_pwr_seq
  import kbc_pwr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             halt_req,
  input  logic             stop_req,
  input  logic             core_reset,
  input  logic             host_wr,
  input  logic             ibf_ie,
  input  logic             osc_ready,
  input  logic [CNT_W-1:0] settle_len,
  output logic             osc_en,
  output logic             core_clk_en,
  output logic             alu_clk_en,
  output logic             wake_stb,
  output logic [1:0]       resume_code
);
  pwr_state_t state;
  logic       settle_done;

  kbc_pwr_settle #(.CNT_W(CNT_W)) u_settle (
    .clk    (clk),
    .arst_n (arst_n),
    .active (state == ST_SETTLE),
    .stable (osc_ready),
    .limit  (settle_len),
    .done   (settle_done)
  );

  kbc_pwr_fsm u_fsm (
    .clk         (clk),
    .arst_n      (arst_n),
    .halt_req    (halt_req),
    .stop_req    (stop_req),
    .core_reset  (core_reset),
    .host_wr     (host_wr),
    .ibf_ie      (ibf_ie),
    .settle_done (settle_done),
    .state       (state),
    .wake_stb    (wake_stb),
    .resume_code (resume_code)
  );

  assign osc_en      = (state != ST_DEEP);
  assign core_clk_en = (state == ST_AWAKE) || (state == ST_SHALLOW);
  assign alu_clk_en  = (state == ST_AWAKE);
endmodule

// File: rtl/kbc_pwr_chk.sv
module kbc_pwr_chk #(
  parameter int CNT_W = 8
) (
  input logic       clk,
  input logic       arst_n,
  input logic       halt_req,
  input logic       stop_req,
  input logic       core_reset,
  input logic       host_wr,
  input logic       ibf_ie,
  input logic       osc_ready,
  input logic       osc_en,
  input logic       core_clk_en,
  input logic       alu_clk_en,
  input logic       wake_stb,
  input logic [1:0] resume_code
);
  a_r2_halt_shallow: assert property (@(posedge clk) disable iff (!arst_n)
    alu_clk_en && halt_req && !stop_req |=> !alu_clk_en && core_clk_en && osc_en);

  a_r3_stop_deep: assert property (@(posedge clk) disable iff (!arst_n)
    core_clk_en && stop_req && !(!alu_clk_en && (host_wr || core_reset))
    |=> !osc_en && !core_clk_en && !alu_clk_en);

  a_r4_host_wake: assert property (@(posedge clk) disable iff (!arst_n)
    !alu_clk_en && core_clk_en && host_wr && !core_reset
    |=> wake_stb && alu_clk_en && resume_code == {1'b0, $past(ibf_ie)});

  a_r5_reset_wake: assert property (@(posedge clk) disable iff (!arst_n)
    !alu_clk_en && core_clk_en && core_reset |=> wake_stb && resume_code == 2'b10);

  a_r6_hold_unready: assert property (@(posedge clk) disable iff (!arst_n)
    !core_clk_en && !osc_ready |=> !core_clk_en);

  a_r7_deep_stays: assert property (@(posedge clk) disable iff (!arst_n)
    !osc_en && !core_reset && !host_wr |=> !osc_en);

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!arst_n)
    wake_stb |=> !wake_stb);

  a_r8_code_idle: assert property (@(posedge clk) disable iff (!arst_n)
    !wake_stb |-> resume_code == 2'b00);

  a_r9_awake_quiet: assert property (@(posedge clk) disable iff (!arst_n)
    alu_clk_en && !halt_req && !stop_req |=> alu_clk_en && !wake_stb);
endmodule

bind kbc_pwr_seq kbc_pwr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .arst_n      (arst_n),
  .halt_req    (halt_req),
  .stop_req    (stop_req),
  .core_reset  (core_reset),
  .host_wr     (host_wr),
  .ibf_ie      (ibf_ie),
  .osc_ready   (osc_ready),
  .osc_en      (osc_en),
  .core_clk_en (core_clk_en),
  .alu_clk_en  (alu_clk_en),
  .wake_stb    (wake_stb),
  .resume_code (resume_code)
);

// File: tb/sim_kbc_pwr_seq.sv
`timescale 1ns/1ps
module sim_kbc_pwr_seq;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic halt_req = 0, stop_req = 0, core_reset = 0, host_wr = 0, ibf_ie = 0, osc_ready = 1;
  logic [CNT_W-1:0] settle_len = '0;
  logic osc_en, core_clk_en, alu_clk_en, wake_stb;
  logic [1:0] resume_code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kbc_pwr_seq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .arst_n(arst_n), .halt_req(halt_req), .stop_req(stop_req),
    .core_reset(core_reset), .host_wr(host_wr), .ibf_ie(ibf_ie),
    .osc_ready(osc_ready), .settle_len(settle_len), .osc_en(osc_en),
    .core_clk_en(core_clk_en), .alu_clk_en(alu_clk_en),
    .wake_stb(wake_stb), .resume_code(resume_code)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int en3();
    return {osc_en, core_clk_en, alu_clk_en};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_halt(); halt_req = 1; tick(); halt_req = 0; endtask
  task automatic pulse_stop(); stop_req = 1; tick(); stop_req = 0; endtask

  // src: 0 host write, 1 core reset, 2 both
  task automatic pulse_wake(input int src);
    host_wr = (src != 1);
    core_reset = (src != 0);
    tick();
    host_wr = 0;
    core_reset = 0;
  endtask

  function automatic int exp_code(input int src, input bit ie);
    if (src != 0) return 2;
    return ie ? 1 : 0;
  endfunction

  task automatic wait_release(output int n);
    n = 0;
    while (!core_clk_en && n < 300) begin
      tick();
      n++;
    end
  endtask

  initial begin
    int n;
    #30;
    tick();
    arst_n = 1;
    tick();
    chk("R1 enables", en3(), 7);
    chk("R1 strobe", wake_stb, 0);
    chk("R1 code", resume_code, 0);

    // R9: wake sources while awake
    pulse_wake(0); chk("R9 host_wr awake strobe", wake_stb, 0); chk("R9 enables", en3(), 7);
    pulse_wake(1); chk("R9 core_reset awake strobe", wake_stb, 0); chk("R9 enables", en3(), 7);

    // R2, R4, R5, R8: shallow sleep sweep
    for (int ie = 0; ie < 2; ie++) begin
      for (int src = 0; src < 3; src++) begin
        ibf_ie = ie[0];
        pulse_halt();
        chk("R2 shallow enables", en3(), 6);
        tick();
        chk("R2 shallow holds", en3(), 6);
        pulse_wake(src);
        chk("R4 wake enables", en3(), 7);
        chk("R4 wake strobe", wake_stb, 1);
        chk(src == 0 ? "R4 code" : "R5 code", resume_code, exp_code(src, ie[0]));
        tick();
        chk("R8 strobe single", wake_stb, 0);
        chk("R8 code idle", resume_code, 0);
      end
    end

    // R3: stop from awake, from shallow, with halt together
    osc_ready = 1;
    settle_len = 0;
    pulse_stop(); chk("R3 stop from awake", en3(), 0);
    pulse_wake(0); wait_release(n);
    pulse_halt(); pulse_stop(); chk("R3 stop from shallow", en3(), 0);
    pulse_wake(0); wait_release(n);
    halt_req = 1; stop_req = 1; tick(); halt_req = 0; stop_req = 0;
    chk("R3 stop wins over halt", en3(), 0);
    tick();
    chk("R3 deep holds", en3(), 0);
    pulse_wake(1); wait_release(n);

    // R6, R5: settle length sweep
    for (int len = 0; len < 6; len++) begin
      for (int src = 0; src < 3; src++) begin
        settle_len = len[CNT_W-1:0];
        ibf_ie = src[0];
        pulse_stop();
        pulse_wake(src);
        chk("R6 osc on after wake", en3(), 4);
        wait_release(n);
        chk("R6 settle cycles", n, len + 1);
        chk("R6 release strobe", wake_stb, 1);
        chk(src == 0 ? "R6 code" : "R5 deep code", resume_code, exp_code(src, src[0]));
        tick();
        chk("R8 strobe single deep", wake_stb, 0);
      end
    end

    // R6: oscillator drop restarts count
    settle_len = 3;
    ibf_ie = 1;
    pulse_stop();
    osc_ready = 0;
    pulse_wake(0);
    tick(); tick();
    chk("R6 held while unready", en3(), 4);
    osc_ready = 1;
    tick(); tick();
    osc_ready = 0;
    tick();
    chk("R6 held after drop", en3(), 4);
    osc_ready = 1;
    wait_release(n);
    chk("R6 count restarts", n, 4);
    chk("R6 drop code", resume_code, 1);
    tick();

    // R7: requests ignored while settling, reset upgrades code
    settle_len = 4;
    ibf_ie = 0;
    pulse_stop();
    pulse_wake(0);
    pulse_stop();
    chk("R7 stop ignored", en3(), 4);
    pulse_halt();
    pulse_wake(0);
    n = 3;
    while (!core_clk_en && n < 300) begin tick(); n++; end
    chk("R7 release time kept", n, 5);
    chk("R7 code kept", resume_code, 0);
    tick();
    settle_len = 4;
    ibf_ie = 1;
    pulse_stop();
    pulse_wake(0);
    tick();
    pulse_wake(1);
    n = 2;
    while (!core_clk_en && n < 300) begin tick(); n++; end
    chk("R7 release with reset", n, 5);
    chk("R7 reset upgrades code", resume_code, 2);
    tick();
    chk("R7 awake after", en3(), 7);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule